// File: doc/BRIEF.md
# Scanline Interrupt Counter from Nametable Fetch Runs

This block watches the picture processor's memory bus and interrupts the CPU after a programmed number of scanlines. It does not look at any pattern-table address edge. Instead it treats a run of back-to-back nametable reads as the end of a scanline. Such reads are recognised by address line 13 being high when the read strobe falls.

Each completed run advances a down-counter. When that counter runs out, it reloads from a latch and, if interrupts are enabled, pulls an active-low interrupt line. The CPU has four write-only controls:

- load the count,
- acknowledge the interrupt,
- disable it (which also clears a pending one),
- enable it.

The bus inputs are asynchronous and pass through a configurable synchroniser first.

Top module: `scanirq_top`

## Requirements
- R1: After reset, irq_n is high, the interrupt is disabled, and the counter and reload latch both hold zero. An enable followed by one scanline therefore expires at once.
- R2: A nametable fetch is a falling edge of the synchronised ppu_rd_n while ppu_a13 is high. Four consecutive nametable fetches make one scanline end, and the next nametable fetch starts a new run. Eight fetches in a row give two scanline ends, and seven give one.
- R3: A fetch with ppu_a13 low resets the run count to zero, and only falling edges of ppu_rd_n count as fetches.
- R4: A write with wr_sel = 0 loads wr_data into both the reload latch and the counter. If it coincides with a scanline end, the write takes precedence.
- R5: At a scanline end with the counter above 1, the counter decreases by one and nothing expires.
- R6: At a scanline end with the counter at 0 or 1, the counter reloads from the latch and expires. A latch value N ≥ 1 thus expires every N scanlines, and a latch of 0 expires on every scanline.
- R7: An expiry while enabled drives irq_n low. irq_n stays low until a write with wr_sel = 1 (acknowledge) or wr_sel = 2 (disable), and a clearing write wins over a coincident expiry.
- R8: While disabled (after reset or a wr_sel = 2 write), expiries leave irq_n high. A later write with wr_sel = 3 enables the interrupt without raising it for expiries that came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ppu_a13 | input | 1 | Picture bus address line 13, asynchronous |
| ppu_rd_n | input | 1 | Picture bus read strobe, active low, asynchronous |
| wr_en | input | 1 | CPU register write strobe, one clock per write |
| wr_sel | input | 2 | Register select: 0 load, 1 acknowledge, 2 disable, 3 enable |
| wr_data | input | CNT_W | Count value for a load write |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions take for granted that ppu_rd_n stays in each level for at least two clocks. They also assume ppu_a13 is settled before the strobe falls and holds until after it, so that both lines cross the synchroniser together. CPU writes are assumed to last one clock each.

The stimulus changes every bus phase on the falling clock edge and holds it for several clocks. Between bursts it leaves enough idle cycles for each result to pass through the synchroniser and the counter before irq_n is sampled.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

    typedef enum logic [1:0] {
        SEL_LOAD = 2'd0,
        SEL_ACK  = 2'd1,
        SEL_OFF  = 2'd2,
        SEL_ON   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic load;
        logic ack;
        logic off;
        logic on;
    } cpu_cmd_t;

    function automatic cpu_cmd_t decode_cmd(input logic wen, input logic [1:0] sel);
        cpu_cmd_t c;
        c = '0;
        if (wen) begin
            case (reg_sel_e'(sel))
                SEL_LOAD: c.load = 1'b1;
                SEL_ACK:  c.ack  = 1'b1;
                SEL_OFF:  c.off  = 1'b1;
                SEL_ON:   c.on   = 1'b1;
                default:  c      = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/scanirq_fetch_detect.sv
module scanirq_fetch_detect #(
    parameter int SYNC_STAGES = 2,
    parameter int NT_RUN      = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic a13_raw,
    input  logic rd_n_raw,
    output logic line_end
);
    localparam int RUN_W = $clog2(NT_RUN + 1);

    logic [SYNC_STAGES-1:0] a13_sync;
    logic [SYNC_STAGES-1:0] rd_sync;
    logic                   rd_last;
    logic [RUN_W-1:0]       run_cnt;
    logic                   a13_now, rd_now, fetch_evt, nt_fetch, run_full;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) begin
                    a13_sync <= '0;
                    rd_sync  <= '1;
                end else begin
                    a13_sync <= a13_raw;
                    rd_sync  <= rd_n_raw;
                end
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) begin
                    a13_sync <= '0;
                    rd_sync  <= '1;
                end else begin
                    a13_sync <= {a13_sync[SYNC_STAGES-2:0], a13_raw};
                    rd_sync  <= {rd_sync[SYNC_STAGES-2:0], rd_n_raw};
                end
            end
        end
    endgenerate

    assign a13_now   = a13_sync[SYNC_STAGES-1];
    assign rd_now    = rd_sync[SYNC_STAGES-1];
    assign fetch_evt = rd_last & ~rd_now;
    assign nt_fetch  = fetch_evt & a13_now;
    assign run_full  = (run_cnt == RUN_W'(NT_RUN - 1));
    assign line_end  = nt_fetch & run_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_last <= 1'b1;
            run_cnt <= '0;
        end else begin
            rd_last <= rd_now;
            if (fetch_evt) begin
                if (!a13_now || run_full) run_cnt <= '0;
                else                      run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    AST_RUN_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        run_cnt < RUN_W'(NT_RUN)); // R2
    AST_PATTERN_FETCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (fetch_evt && !a13_now) |=> (run_cnt == '0)); // R3
    AST_NO_EDGE_HOLDS_RUN: assert property (@(posedge clk) disable iff (rst)
        !fetch_evt |=> $stable(run_cnt)); // R3

endmodule

// File: rtl/scanirq_line_counter.sv
module scanirq_line_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             line_end,
    output logic             expire
);
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] latch;
    logic             at_end;

    assign at_end = (count <= CNT_W'(1));
    assign expire = line_end & ~load & at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            latch <= '0;
        end else if (load) begin
            count <= load_val;
            latch <= load_val;
        end else if (line_end) begin
            if (at_end) count <= latch;
            else        count <= count - 1'b1;
        end
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val) && latch == $past(load_val))); // R4
    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(latch)); // R4
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (line_end && !load && count > CNT_W'(1)) |=> (count == $past(count) - 1'b1)); // R5
    AST_WRAP_FROM_LATCH: assert property (@(posedge clk) disable iff (rst)
        expire |=> (count == $past(latch))); // R6

endmodule

// File: rtl/scanirq_irq_ctrl.sv
module scanirq_irq_ctrl
    import scanirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cpu_cmd_t cmd,
    input  logic     expire,
    output logic     irq_n
);
    logic irq_en;
    logic pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en  <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (cmd.on)  irq_en <= 1'b1;
            if (cmd.off) irq_en <= 1'b0;
            if (cmd.ack || cmd.off)      pending <= 1'b0;
            else if (expire && irq_en)   pending <= 1'b1;
        end
    end

    assign irq_n = ~pending;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (irq_n && !irq_en)); // R1
    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (cmd.ack || cmd.off) |=> irq_n); // R7
    AST_RAISE_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        (expire && irq_en && !cmd.ack && !cmd.off) |=> !irq_n); // R7
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !cmd.ack && !cmd.off) |=> !irq_n); // R7
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> irq_n); // R8

endmodule

// File: rtl/scanirq_top.sv
module scanirq_top
    import scanirq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int NT_RUN      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ppu_a13,
    input  logic             ppu_rd_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq_n
);
    cpu_cmd_t cmd;
    logic     line_end;
    logic     expire;

    assign cmd = decode_cmd(wr_en, wr_sel);

    scanirq_fetch_detect #(
        .SYNC_STAGES(SYNC_STAGES),
        .NT_RUN     (NT_RUN)
    ) u_detect (
        .clk     (clk),
        .rst     (rst),
        .a13_raw (ppu_a13),
        .rd_n_raw(ppu_rd_n),
        .line_end(line_end)
    );

    scanirq_line_counter #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk     (clk),
        .rst     (rst),
        .load    (cmd.load),
        .load_val(wr_data),
        .line_end(line_end),
        .expire  (expire)
    );

    scanirq_irq_ctrl u_irq (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .expire(expire),
        .irq_n (irq_n)
    );

endmodule

// File: tb/tb_scanirq_top.sv
module tb_scanirq_top;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ppu_a13 = 1'b0;
    logic             ppu_rd_n = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             irq_n;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    typedef struct {
        logic  lvl;
        string tag;
    } exp_t;

    exp_t q[$];
    event sample_ev;

    always #5 clk = ~clk;

    scanirq_top #(.CNT_W(CNT_W)) dut (
        .clk     (clk),
        .rst     (rst),
        .ppu_a13 (ppu_a13),
        .ppu_rd_n(ppu_rd_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .irq_n   (irq_n)
    );

    // driver side of the scoreboard
    task automatic expect_irq(input logic lvl, input string tag);
        exp_t e;
        e.lvl = lvl;
        e.tag = tag;
        q.push_back(e);
        -> sample_ev;
        @(negedge clk);
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(sample_ev);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (irq_n !== e.lvl) begin
                    errors++;
                    $display("FAIL %s: irq_n=%0b expected %0b", e.tag, irq_n, e.lvl);
                end
            end
        end
    end

    task automatic fetch(input logic a13);
        @(negedge clk);
        ppu_a13 = a13;
        ppu_rd_n = 1'b1;
        repeat (2) @(negedge clk);
        ppu_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        ppu_rd_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic nt_fetches(input int n);
        for (int i = 0; i < n; i++) fetch(1'b1);
        settle();
    endtask

    task automatic scanline();
        nt_fetches(4);
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_irq(1'b1, "R1 reset leaves irq_n high");

        // R1: counter and latch at zero, so the first scanline expires
        cpu_write(2'd3, '0);
        scanline();
        expect_irq(1'b0, "R1 zero counter expires on first line");
        cpu_write(2'd1, '0);
        expect_irq(1'b1, "R7 acknowledge releases irq_n");
        scanline();
        expect_irq(1'b0, "R6 zero latch expires every line");
        cpu_write(2'd1, '0);

        // R4 R5 R6: load 3
        cpu_write(2'd0, 8'd3);
        scanline();
        expect_irq(1'b1, "R5 line 1 of 3");
        scanline();
        expect_irq(1'b1, "R5 line 2 of 3");
        scanline();
        expect_irq(1'b0, "R4 R6 line 3 of 3 expires");
        cpu_write(2'd1, '0);
        expect_irq(1'b1, "R7 acknowledge after load 3");
        scanline();
        expect_irq(1'b1, "R6 reloaded count line 1");
        scanline();
        expect_irq(1'b1, "R6 reloaded count line 2");
        scanline();
        expect_irq(1'b0, "R6 reloaded count expires");
        repeat (20) @(negedge clk);
        expect_irq(1'b0, "R7 irq_n held until cleared");
        cpu_write(2'd2, '0);
        expect_irq(1'b1, "R7 disable clears irq_n");

        // R8: disabled expiries are ignored
        scanline();
        expect_irq(1'b1, "R8 disabled line 1");
        scanline();
        expect_irq(1'b1, "R8 disabled line 2");
        scanline();
        expect_irq(1'b1, "R8 disabled expiry ignored");
        cpu_write(2'd3, '0);
        expect_irq(1'b1, "R8 enable raises nothing stale");

        // R2: run restarts after the fourth fetch
        cpu_write(2'd0, 8'd2);
        nt_fetches(7);
        expect_irq(1'b1, "R2 seven fetches make one line");
        nt_fetches(1);
        expect_irq(1'b0, "R2 eighth fetch completes second line");
        cpu_write(2'd1, '0);

        // R3: pattern fetch breaks the run
        cpu_write(2'd0, 8'd1);
        for (int i = 0; i < 3; i++) fetch(1'b1);
        fetch(1'b0);
        nt_fetches(3);
        expect_irq(1'b1, "R3 broken run gives no line");
        nt_fetches(1);
        expect_irq(1'b0, "R3 fresh run of four ends a line");
        cpu_write(2'd1, '0);
        expect_irq(1'b1, "R7 final acknowledge");

        // R3: a long low strobe counts once
        cpu_write(2'd0, 8'd1);
        for (int i = 0; i < 3; i++) fetch(1'b1);
        @(negedge clk);
        ppu_a13 = 1'b1;
        ppu_rd_n = 1'b0;
        repeat (30) @(negedge clk);
        expect_irq(1'b0, "R3 held strobe counts as one fetch");
        ppu_rd_n = 1'b1;
        repeat (30) @(negedge clk);
        cpu_write(2'd1, '0);
        expect_irq(1'b1, "R3 rising edge adds no line");

        settle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule